// File: doc/BRIEF.md
# Signed-Count Double-Word Arithmetic Shifter

This execution unit carries out one register-to-register instruction: an arithmetic shift of a 32-bit register pair by a signed count. It has its own sixteen-entry file of 16-bit registers.

A 16-bit instruction word selects two registers. The pair register gives the high word, and the register after it gives the low word. The count register holds a two's-complement count. A count of zero or more shifts the pair left. A negative count shifts it right by the count's magnitude. The result goes back into the pair.

On every executed instruction the unit also produces two outputs:
- a one-hot condition status that describes the result;
- a fixed-point overflow flag. It is raised when the sign bit changes during a left shift, or when the count's magnitude is too large to shift.

The surrounding core loads the register file through a write port and watches it through a read port. It strobes one instruction per cycle. On the next clock edge the unit writes back and raises a done pulse, or raises an illegal pulse if the opcode is not recognised.

Top module: `dsa_shift_unit`

## Requirements
- R1: The instruction word carries the opcode in bits 15:8, the pair register index A in bits 7:4 and the count register index B in bits 3:0. Opcode 8'h6E, when strobed with `instr_valid`, executes. `done` is high for exactly the cycle after the strobe, and the register file and `cond_status` show the result from that same cycle.
- R2: The operand is {reg[A], reg[A+1]}, with reg[A] as the high word. A+1 wraps modulo 16, so A = 15 pairs with register 0.
- R3: A count N with bit 15 clear shifts the operand left by N. Zeros enter at bit 0. If the top N+1 bits of the operand are all equal, `fx_ovf` stays low.
- R4: A count with bit 15 set shifts the operand right by -N. Copies of bit 31 fill the vacated high positions. A right shift never raises `fx_ovf`.
- R5: A zero count leaves the pair unchanged, but `cond_status` is still updated from the pair.
- R6: When |N| is 32 or more, `fx_ovf` is raised and the pair, the count register and `cond_status` all keep their values.
- R7: If the sign bit takes a different value at any step of a left shift, `fx_ovf` is raised. The shifted result is still written back.
- R8: `cond_status` is 4'b0010 for a zero result, 4'b0001 for a negative result and 4'b0100 for a positive nonzero result.
- R9: The count register is unchanged unless it is one of the pair. When A = B, reg[B] receives the shifted high word.
- R10: A strobed word whose opcode is not 8'h6E raises `illegal` for the next cycle. It does not raise `done` or `fx_ovf`, and it changes no register and does not change `cond_status`.
- R11: After reset, `done`, `illegal` and `fx_ovf` are 0, `cond_status` is 4'b0000 and every register reads 0.
- R12: When `ld_en` is high and no instruction is strobed, register `ld_addr` takes `ld_data` on the clock edge. `rd_data` shows register `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 16 | Opcode, pair index, count index |
| ld_en | input | 1 | Register load enable |
| ld_addr | input | 4 | Register load index |
| ld_data | input | 16 | Register load value |
| rd_addr | input | 4 | Read port index |
| rd_data | output | 16 | Read port value |
| done | output | 1 | Executed-instruction pulse |
| illegal | output | 1 | Unrecognised-opcode pulse |
| fx_ovf | output | 1 | Fixed-point overflow pulse, valid with `done` |
| cond_status | output | 4 | One-hot condition status |

## Verification
The assertions assume that `instr_valid` and `instr_word` are known in every cycle after reset. They also assume that no register load lands in the same cycle as an executed instruction. The stimulus drives both inputs on the falling edge, returns `instr_valid` low between instructions, and keeps `ld_en` low whenever an instruction is strobed. Within those limits, random words mix counts near the ±32 boundary with occasional full-range counts. They cover pair indices that wrap and count registers that overlap the pair.

// File: rtl/dsa_pkg.sv
`timescale 1ns/1ps
package dsa_pkg;
  localparam int DATA_W  = 16;
  localparam int REG_CNT = 16;
  localparam int ADDR_W  = $clog2(REG_CNT);
  localparam int OPC_W   = 8;
  localparam int INSTR_W = OPC_W + 2 * ADDR_W;
  localparam int CS_W    = 4;
  localparam logic [OPC_W-1:0] OPC_DSHIFT = 8'h6E;

  localparam logic [CS_W-1:0] CS_ZERO = 4'b0010;
  localparam logic [CS_W-1:0] CS_NEG  = 4'b0001;
  localparam logic [CS_W-1:0] CS_POS  = 4'b0100;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [ADDR_W-1:0] ra;
    logic [ADDR_W-1:0] rb;
  } instr_t;
endpackage

// File: rtl/dsa_regfile.sv
`timescale 1ns/1ps
module dsa_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  parameter int ADDR_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic [ADDR_W-1:0] cnt_addr,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] hi_data,
  output logic [DATA_W-1:0] lo_data,
  output logic [DATA_W-1:0] cnt_data,
  output logic [DATA_W-1:0] dbg_data,
  input  logic              pair_we,
  input  logic [DATA_W-1:0] pair_hi,
  input  logic [DATA_W-1:0] pair_lo,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data
);
  logic [DATA_W-1:0] regs [REG_CNT];
  logic [ADDR_W-1:0] lo_addr;

  assign lo_addr  = hi_addr + ADDR_W'(1);
  assign hi_data  = regs[hi_addr];
  assign lo_data  = regs[lo_addr];
  assign cnt_data = regs[cnt_addr];
  assign dbg_data = regs[dbg_addr];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic              hit_hi, hit_lo, hit_ld, en;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      hit_hi = pair_we && (hi_addr == ADDR_W'(g));
      hit_lo = pair_we && (lo_addr == ADDR_W'(g));
      hit_ld = ld_we && (ld_addr == ADDR_W'(g));
      en     = hit_hi || hit_lo || hit_ld;
      if (hit_hi)      nxt = pair_hi;
      else if (hit_lo) nxt = pair_lo;
      else             nxt = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= nxt;
    end
  end
endmodule

// File: rtl/dsa_shift_core.sv
`timescale 1ns/1ps
module dsa_shift_core #(
  parameter int DATA_W = 16,
  localparam int OP_W  = 2 * DATA_W,
  localparam int SH_W  = $clog2(OP_W)
) (
  input  logic [OP_W-1:0]   operand,
  input  logic [DATA_W-1:0] count,
  output logic [OP_W-1:0]   result,
  output logic              ovf,
  output logic              nop
);
  logic              neg;
  logic [DATA_W:0]   mag;
  logic [SH_W-1:0]   amt;
  logic [SH_W:0]     amt_p1;
  logic [OP_W-1:0]   window;
  logic [OP_W-1:0]   sign_diff;
  logic [OP_W-1:0]   left_res;
  logic [OP_W-1:0]   right_res;
  logic signed [OP_W-1:0] s_op;

  for (genvar k = 0; k < OP_W; k++) begin : g_diff
    assign sign_diff[k] = operand[k] ^ operand[OP_W-1];
  end

  always_comb begin
    neg    = count[DATA_W-1];
    mag    = neg ? ({1'b0, ~count} + (DATA_W+1)'(1)) : {1'b0, count};
    nop    = (mag >= (DATA_W+1)'(OP_W));
    amt    = mag[SH_W-1:0];
    amt_p1 = {1'b0, amt} + (SH_W+1)'(1);
    window = ~({OP_W{1'b1}} >> amt_p1);
    s_op   = operand;
    left_res  = operand << amt;
    right_res = s_op >>> amt;
    result = neg ? right_res : left_res;
    ovf    = nop || (!neg && |(sign_diff & window));
  end
endmodule

// File: rtl/dsa_cond_gen.sv
`timescale 1ns/1ps
module dsa_cond_gen
  import dsa_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] value,
  output logic [CS_W-1:0] cs
);
  always_comb begin
    if (value == '0)        cs = CS_ZERO;
    else if (value[OP_W-1]) cs = CS_NEG;
    else                    cs = CS_POS;
  end
endmodule

// File: rtl/dsa_shift_unit.sv
`timescale 1ns/1ps
module dsa_shift_unit
  import dsa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               done,
  output logic               illegal,
  output logic               fx_ovf,
  output logic [CS_W-1:0]    cond_status
);
  localparam int OP_W = 2 * DATA_W;

  instr_t            ins;
  logic              is_op, exec_ok;
  logic [DATA_W-1:0] hi_w, lo_w, cnt_w;
  logic [OP_W-1:0]   shifted;
  logic              core_ovf, core_nop;
  logic [CS_W-1:0]   cs_new;
  logic              pair_we, ld_we;

  logic [CS_W-1:0]   cs_q, cs_d;
  logic              done_q, done_d;
  logic              ill_q, ill_d;
  logic              ovf_q, ovf_d;

  assign ins     = instr_t'(instr_word);
  assign is_op   = (ins.opc == OPC_DSHIFT);
  assign exec_ok = instr_valid && is_op;
  assign pair_we = exec_ok && !core_nop;
  assign ld_we   = ld_en && !instr_valid;

  dsa_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_addr  (ins.ra),
    .cnt_addr (ins.rb),
    .dbg_addr (rd_addr),
    .hi_data  (hi_w),
    .lo_data  (lo_w),
    .cnt_data (cnt_w),
    .dbg_data (rd_data),
    .pair_we  (pair_we),
    .pair_hi  (shifted[OP_W-1:DATA_W]),
    .pair_lo  (shifted[DATA_W-1:0]),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data)
  );

  dsa_shift_core #(.DATA_W(DATA_W)) u_core (
    .operand (({hi_w, lo_w})),
    .count   (cnt_w),
    .result  (shifted),
    .ovf     (core_ovf),
    .nop     (core_nop)
  );

  dsa_cond_gen #(.OP_W(OP_W)) u_cs (
    .value (shifted),
    .cs    (cs_new)
  );

  always_comb begin
    cs_d   = pair_we ? cs_new : cs_q;
    done_d = exec_ok;
    ovf_d  = exec_ok && core_ovf;
    ill_d  = instr_valid && !is_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      done_q <= done_d;
      ill_q  <= ill_d;
      ovf_q  <= ovf_d;
    end
  end

  assign cond_status = cs_q;
  assign done        = done_q;
  assign illegal     = ill_q;
  assign fx_ovf      = ovf_q;
endmodule

// File: rtl/dsa_shift_unit_chk.sv
`timescale 1ns/1ps
module dsa_shift_unit_chk
  import dsa_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr_word,
  input logic               done,
  input logic               illegal,
  input logic               fx_ovf,
  input logic [CS_W-1:0]    cond_status
);
  logic op_hit;
  assign op_hit = (instr_word[INSTR_W-1 -: OPC_W] == OPC_DSHIFT);

  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && op_hit) |=> (done && !illegal));

  a_r1_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!done && !illegal && !fx_ovf));

  a_r10_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !op_hit) |=> (illegal && !done && !fx_ovf));

  a_r10_illegal_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(cond_status));

  a_r6_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fx_ovf |-> done);

  a_r8_cs_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_status));

  a_r8_cs_update_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$stable(cond_status)) |-> $onehot(cond_status));
endmodule

bind dsa_shift_unit dsa_shift_unit_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .done        (done),
  .illegal     (illegal),
  .fx_ovf      (fx_ovf),
  .cond_status (cond_status)
);

// File: tb/dsa_shift_unit_tb_top.sv
`timescale 1ns/1ps
module dsa_shift_unit_tb_top;
  localparam real HALF = 2.5;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        ld_en;
  logic [3:0]  ld_addr;
  logic [15:0] ld_data;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;
  logic        done, illegal, fx_ovf;
  logic [3:0]  cond_status;

  int n_cmp;
  int n_bad;
  bit finished;

  logic [15:0] m_reg [16];
  logic [3:0]  m_cs;

  dsa_shift_unit dut_i (
    .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_word (instr_word),
    .ld_en (ld_en), .ld_addr (ld_addr), .ld_data (ld_data), .rd_addr (rd_addr),
    .rd_data (rd_data), .done (done), .illegal (illegal), .fx_ovf (fx_ovf),
    .cond_status (cond_status)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i);
      #0.1;
      check(tag, $sformatf("reg%0d", i), {16'h0, rd_data}, {16'h0, m_reg[i]});
    end
  endtask

  task automatic load(int idx, logic [15:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 4'(idx); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
    m_reg[idx] = val;
  endtask

  function automatic logic [3:0] cs_of(logic [31:0] v);
    if (v == 32'h0) return 4'b0010;
    if (v[31])      return 4'b0001;
    return 4'b0100;
  endfunction

  // behavioural reference, one bit per step
  task automatic exec(logic [7:0] opc, int ra, int rb, string tag);
    logic [31:0] v, nv;
    int  n, lo;
    bit  e_done, e_ill, e_ovf;
    lo = (ra + 1) % 16;
    e_done = 0; e_ill = 0; e_ovf = 0;
    if (opc != 8'h6E) begin
      e_ill = 1;
    end else begin
      e_done = 1;
      n = int'($signed(m_reg[rb]));
      v = {m_reg[ra], m_reg[lo]};
      if (n >= 32 || n <= -32) begin
        e_ovf = 1;
      end else begin
        if (n >= 0) begin
          for (int s = 0; s < n; s++) begin
            nv = v << 1;
            if (nv[31] != v[31]) e_ovf = 1;
            v = nv;
          end
        end else begin
          for (int s = 0; s < -n; s++) v = {v[31], v[31:1]};
        end
        m_reg[ra] = v[31:16];
        m_reg[lo] = v[15:0];
        m_cs = cs_of(v);
      end
    end
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = {opc, 4'(ra), 4'(rb)};
    @(negedge clk);
    instr_valid = 1'b0;
    check(tag, "done",    {31'h0, done},    {31'h0, e_done});
    check(tag, "illegal", {31'h0, illegal}, {31'h0, e_ill});
    check(tag, "fx_ovf",  {31'h0, fx_ovf},  {31'h0, e_ovf});
    check(tag, "cond_status", {28'h0, cond_status}, {28'h0, m_cs});
    check_regs(tag);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0;
    instr_valid = 0; instr_word = 0; ld_en = 0; ld_addr = 0; ld_data = 0; rd_addr = 0;
    for (int i = 0; i < 16; i++) m_reg[i] = 16'h0;
    m_cs = 4'b0000;
    rst_n = 1'b0;
    #(HALF * 5);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11", "done",    {31'h0, done},    32'h0);
    check("R11", "illegal", {31'h0, illegal}, 32'h0);
    check("R11", "fx_ovf",  {31'h0, fx_ovf},  32'h0);
    check("R11", "cond_status", {28'h0, cond_status}, 32'h0);
    check_regs("R11");

    // R12 loads
    load(2, 16'h0123); load(3, 16'h4567); load(4, 16'd4);
    check_regs("R12");

    exec(8'h6E, 2, 4, "R3");                               // left 4, no flip
    load(5, 16'hFFFC);
    exec(8'h6E, 2, 5, "R4");                               // right 4, positive
    load(2, 16'h8001); load(3, 16'h0000);
    exec(8'h6E, 2, 5, "R4_neg");                           // right 4, sign fill
    load(6, 16'd1); load(2, 16'h4000);
    exec(8'h6E, 2, 6, "R7");                               // sign flips, still written
    load(7, 16'd0); load(2, 16'h0000); load(3, 16'h0000);
    exec(8'h6E, 2, 7, "R5_R8_zero");                       // zero count, zero result
    load(2, 16'h0001);
    exec(8'h6E, 2, 7, "R5_R8_pos");
    load(8, 16'd32);
    exec(8'h6E, 2, 8, "R6_p32");
    load(8, 16'hFFE0);
    exec(8'h6E, 2, 8, "R6_m32");
    load(8, 16'h8000);
    exec(8'h6E, 2, 8, "R6_min");
    load(8, 16'd31); load(2, 16'h0000); load(3, 16'h0001);
    exec(8'h6E, 2, 8, "R7_31");
    load(8, 16'hFFE1); load(2, 16'h8000); load(3, 16'h0000);
    exec(8'h6E, 2, 8, "R4_m31");
    load(15, 16'hC000); load(0, 16'h1234); load(9, 16'd2);
    exec(8'h6E, 15, 9, "R2_wrap");
    load(10, 16'd3);
    exec(8'h6E, 10, 10, "R9_same");
    exec(8'h6E, 9, 10, "R9_low");
    exec(8'h6D, 2, 8, "R10");
    exec(8'hFF, 15, 0, "R10_ff");
    exec(8'h6E, 11, 12, "R1");

    for (int t = 0; t < 250; t++) begin
      int ra, rb, sel;
      ra = $urandom_range(0, 15);
      rb = $urandom_range(0, 15);
      sel = $urandom_range(0, 9);
      if (sel < 3) load(ra, 16'($urandom));
      if (sel < 3) load((ra + 1) % 16, 16'($urandom));
      if (sel < 6) load(rb, 16'($urandom_range(0, 80) - 40));
      else if (sel == 6) load(rb, 16'($urandom));
      exec((sel == 9) ? 8'(($urandom_range(0, 1) == 0) ? 8'h6F : 8'h00) : 8'h6E,
           ra, rb, "R1_rand");
    end
    finish_run();
  end
endmodule